// File: doc/BRIEF.md
# Five-Stage Pipeline Control with Single Write-Port Arbitration

This block is the control path of an in-order pipeline with five stages: fetch, register read/decode, execute, memory access and writeback. Each cycle the fetch side offers one instruction class on a valid/ready stream. Once the block accepts it, the block turns it into a control token. The token moves one slot down the pipe per cycle, alongside the datapath, and the block decodes it into enables for each stage and a register-file write strobe.

The register file has a single write port. A load writes it in stage five. A register-type ALU operation naturally writes it in stage four. The parameter `UNIFORM_WB` selects how the clash between them is settled:
- **Bubble mode (0):** when a register-type operation follows a load directly, it is held at fetch for one cycle and an empty token enters the pipe in its place.
- **Uniform mode (1):** every writer uses stage five, the memory stage of a register-type operation is idle, and no stall ever occurs.

Back-pressure rules work as follows. `in_ready` falls only in bubble mode, only while `in_valid` is high with a register-type class, and only while the decode slot holds a load. That same cycle `fetch_stall` rises. The source must keep the same class on the input until it is accepted, which happens on the next cycle. `in_ready` may depend on `in_class`.

Top module: `pipe_ctl`

## Requirements
- R1: During and right after reset all slots are empty. `rd_en`, `alu_en`, `br_en`, `dmem_en`, `dmem_we`, `rf_we`, `fetch_en` and `fetch_stall` are low, and `in_ready` is high.
- R2: The class encoding on `in_class` is 0 none, 1 load, 2 register-type ALU, 3 store, 4 branch-if-equal. An instruction is accepted, and `fetch_en` is high, in a cycle where `in_valid` and `in_ready` are both high. A cycle with `in_valid` low puts an empty token into the pipe.
- R3: A token advances exactly one stage per cycle. An accepted class other than none raises `rd_en` one cycle after acceptance and `alu_en` two cycles after.
- R4: The register file is written by at most one instruction in any cycle.
- R5: In bubble mode, a register-type class offered while the decode slot holds a load raises `fetch_stall` and lowers `in_ready` in that same cycle. The held instruction is accepted on the next cycle.
- R6: The cycle after a stall, the decode slot holds an empty token, so `rd_en` is low.
- R7: In bubble mode, `rf_we` rises four cycles after a load is accepted and three cycles after a register-type operation is accepted.
- R8: In uniform mode `in_ready` never falls. `rf_we` rises four cycles after either a load or a register-type operation is accepted.
- R9: A store raises `dmem_en` and `dmem_we` three cycles after acceptance and never causes `rf_we`. A load raises `dmem_en` without `dmem_we`.
- R10: A branch-if-equal raises `br_en` two cycles after acceptance and never causes `rf_we`. A class-none token raises no enable at any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch offers an instruction |
| in_ready | output | 1 | Block accepts the offered instruction |
| in_class | input | 3 | Instruction class (encoding in R2) |
| fetch_stall | output | 1 | Fetch must hold its instruction this cycle |
| fetch_en | output | 1 | Instruction accepted into the pipe this cycle |
| rd_en | output | 1 | Register read/decode stage active |
| alu_en | output | 1 | Execute stage active |
| br_en | output | 1 | Execute stage resolves a branch-if-equal |
| dmem_en | output | 1 | Data memory access in the memory stage |
| dmem_we | output | 1 | Data memory write (store) |
| rf_we | output | 1 | Register-file write strobe |

## Verification
A load's writeback and the writeback of a register-type operation right behind it would land in the same cycle. That collision is provoked by load-then-register pairs, both back to back and separated by idle or none cycles, inside a long mixed stream run on one instance of each mode. A behavioural model tracks the class held in every stage and predicts, each cycle, the handshake, the stall and each enable. Agreement of `rf_we` with the model, together with a property that the memory-stage and writeback-stage writers never coincide, judges the single-port rule.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
  localparam int CLS_W = 3;
  localparam int NSLOT = 4;
  localparam int S_DEC = 0;
  localparam int S_EXE = 1;
  localparam int S_MEM = 2;
  localparam int S_WB  = 3;

  typedef enum logic [CLS_W-1:0] {
    C_NONE  = 3'd0,
    C_LOAD  = 3'd1,
    C_RTYPE = 3'd2,
    C_STORE = 3'd3,
    C_BEQ   = 3'd4
  } cls_e;

  typedef struct packed {
    logic v;
    cls_e cls;
  } tok_t;

  function automatic logic is_cls(tok_t t, cls_e c);
    return t.v && (t.cls == c);
  endfunction

  function automatic logic is_work(tok_t t);
    return t.v && (t.cls != C_NONE);
  endfunction
endpackage

// File: rtl/pipe_ctl_hazard.sv
module pipe_ctl_hazard
  import pipe_ctl_pkg::*;
#(
  parameter int UNIFORM_WB = 0
) (
  input  logic             in_valid,
  input  logic [CLS_W-1:0] in_class,
  input  tok_t             dec_tok,
  output logic             stall
);
  logic clash;

  always_comb begin
    clash = in_valid && (cls_e'(in_class) == C_RTYPE) && is_cls(dec_tok, C_LOAD);
    stall = (UNIFORM_WB == 0) && clash;
  end
endmodule

// File: rtl/pipe_ctl_slots.sv
module pipe_ctl_slots
  import pipe_ctl_pkg::*;
#(
  parameter int N = NSLOT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tok_t           ins_tok,
  output tok_t [N-1:0]   slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= {slot[N-2:0], ins_tok};
  end
endmodule

// File: rtl/pipe_ctl_decode.sv
module pipe_ctl_decode
  import pipe_ctl_pkg::*;
#(
  parameter int UNIFORM_WB = 0
) (
  input  tok_t [NSLOT-1:0] slot,
  output logic             rd_en,
  output logic             alu_en,
  output logic             br_en,
  output logic             dmem_en,
  output logic             dmem_we,
  output logic             rf_we
);
  always_comb begin
    rd_en   = is_work(slot[S_DEC]);
    alu_en  = is_work(slot[S_EXE]);
    br_en   = is_cls(slot[S_EXE], C_BEQ);
    dmem_en = is_cls(slot[S_MEM], C_LOAD) || is_cls(slot[S_MEM], C_STORE);
    dmem_we = is_cls(slot[S_MEM], C_STORE);
  end

  generate
    if (UNIFORM_WB != 0) begin : g_uniform
      assign rf_we = is_cls(slot[S_WB], C_LOAD) || is_cls(slot[S_WB], C_RTYPE);
    end else begin : g_bubble
      assign rf_we = is_cls(slot[S_WB], C_LOAD) || is_cls(slot[S_MEM], C_RTYPE);
    end
  endgenerate
endmodule

// File: rtl/pipe_ctl.sv
module pipe_ctl
  import pipe_ctl_pkg::*;
#(
  parameter int UNIFORM_WB = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CLS_W-1:0] in_class,
  output logic             fetch_stall,
  output logic             fetch_en,
  output logic             rd_en,
  output logic             alu_en,
  output logic             br_en,
  output logic             dmem_en,
  output logic             dmem_we,
  output logic             rf_we
);
  tok_t [NSLOT-1:0] slot;
  tok_t             ins_tok;
  logic             stall;

  pipe_ctl_hazard #(.UNIFORM_WB(UNIFORM_WB)) u_hazard (
    .in_valid (in_valid),
    .in_class (in_class),
    .dec_tok  (slot[S_DEC]),
    .stall    (stall)
  );

  always_comb begin
    in_ready    = !stall;
    fetch_stall = stall;
    fetch_en    = in_valid && !stall;
    ins_tok.v   = fetch_en;
    ins_tok.cls = cls_e'(in_class);
  end

  pipe_ctl_slots #(.N(NSLOT)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_tok (ins_tok),
    .slot    (slot)
  );

  pipe_ctl_decode #(.UNIFORM_WB(UNIFORM_WB)) u_decode (
    .slot    (slot),
    .rd_en   (rd_en),
    .alu_en  (alu_en),
    .br_en   (br_en),
    .dmem_en (dmem_en),
    .dmem_we (dmem_we),
    .rf_we   (rf_we)
  );
endmodule

// File: rtl/pipe_ctl_chk.sv
module pipe_ctl_chk
  import pipe_ctl_pkg::*;
#(
  parameter int UNIFORM_WB = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CLS_W-1:0] in_class,
  input logic             fetch_stall,
  input logic             fetch_en,
  input logic             rd_en,
  input logic             br_en,
  input logic             dmem_we,
  input logic             rf_we,
  input tok_t             mem_tok,
  input tok_t             wb_tok
);
  // R3: an accepted working class reaches the decode stage one cycle later
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && in_class != 3'd0) |=> rd_en);

  // R6: the slot behind a stall is empty
  p_bubble_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> !rd_en);

  // R9: a store writes data memory in the memory stage
  p_store_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && in_class == 3'd3) |-> ##3 dmem_we);

  // R10: a branch resolves in execute
  p_beq_exe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && in_class == 3'd4) |-> ##2 br_en);

  // R2: nothing enters while the input is idle
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !fetch_en);

  generate
    if (UNIFORM_WB != 0) begin : g_uni
      // R8: never stalls
      p_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_ready && !fetch_stall));
      // R8: register-type writes in stage five
      p_rtype_wb5_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && in_class == 3'd2) |-> ##4 rf_we);
      // R4: the only writer sits in writeback
      p_one_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (wb_tok.v && (wb_tok.cls == C_LOAD || wb_tok.cls == C_RTYPE)));
    end else begin : g_bub
      // R5: a register-type op right behind a load stalls
      p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && in_class == 3'd1) |=> ((in_valid && in_class == 3'd2) |-> (fetch_stall && !in_ready)));
      // R7: register-type writes in stage four
      p_rtype_wb4_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && in_class == 3'd2) |-> ##3 rf_we);
      // R4: memory-stage and writeback-stage writers never coincide
      p_one_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !((mem_tok.v && mem_tok.cls == C_RTYPE) && (wb_tok.v && wb_tok.cls == C_LOAD)));
    end
  endgenerate
endmodule

bind pipe_ctl pipe_ctl_chk #(.UNIFORM_WB(UNIFORM_WB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_class    (in_class),
  .fetch_stall (fetch_stall),
  .fetch_en    (fetch_en),
  .rd_en       (rd_en),
  .br_en       (br_en),
  .dmem_we     (dmem_we),
  .rf_we       (rf_we),
  .mem_tok     (slot[pipe_ctl_pkg::S_MEM]),
  .wb_tok      (slot[pipe_ctl_pkg::S_WB])
);

// File: tb/pipe_ctl_bench.sv
module pipe_ctl_bench;
  localparam int PLEN = 300;
  localparam int IDLE = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       v_b, v_u;
  logic [2:0] c_b, c_u;
  logic [8:0] obs_b, obs_u;
  logic       rdy_b, stl_b, fen_b, rd_b, alu_b, br_b, dme_b, dmw_b, rfw_b;
  logic       rdy_u, stl_u, fen_u, rd_u, alu_u, br_u, dme_u, dmw_u, rfw_u;

  pipe_ctl #(.UNIFORM_WB(0)) u_pipe_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(v_b), .in_ready(rdy_b), .in_class(c_b),
    .fetch_stall(stl_b), .fetch_en(fen_b), .rd_en(rd_b), .alu_en(alu_b),
    .br_en(br_b), .dmem_en(dme_b), .dmem_we(dmw_b), .rf_we(rfw_b));

  pipe_ctl #(.UNIFORM_WB(1)) u_pipe_ctl_uni (
    .clk(clk), .rst_n(rst_n), .in_valid(v_u), .in_ready(rdy_u), .in_class(c_u),
    .fetch_stall(stl_u), .fetch_en(fen_u), .rd_en(rd_u), .alu_en(alu_u),
    .br_en(br_u), .dmem_en(dme_u), .dmem_we(dmw_u), .rf_we(rfw_u));

  assign obs_b = {rdy_b, stl_b, fen_b, rd_b, alu_b, br_b, dme_b, dmw_b, rfw_b};
  assign obs_u = {rdy_u, stl_u, fen_u, rd_u, alu_u, br_u, dme_u, dmw_u, rfw_u};

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int prog [PLEN];
  int h [2][5];
  int idx [2];
  int cv [2];
  int cc [2];
  bit acc [2];

  function automatic int hand(int i);
    case (i)
      0: return 1;  1: return 2;  2: return 2;  3: return 1;  4: return 1;
      5: return 2;  6: return 3;  7: return 4;  8: return IDLE; 9: return 0;
      10: return 1; 11: return 3; 12: return 2; 13: return 4; 14: return 1;
      15: return IDLE; 16: return 2; 17: return 1; 18: return 0; 19: return 2;
      20: return 3; 21: return 1; 22: return 2; 23: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string tag, string nm, int m, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s mode=%0d actual=%0b expected=%0b t=%0t", tag, nm, m, act, exp, $time);
    end
  endtask

  task automatic check_model(int m);
    bit uni = (m == 1);
    logic [8:0] o = (m == 0) ? obs_b : obs_u;
    bit stall = !uni && cv[m] != 0 && cc[m] == 2 && h[m][1] == 1;
    bit wr = (h[m][4] == 1) || (uni ? h[m][4] == 2 : h[m][3] == 2);
    acc[m] = cv[m] != 0 && !stall;
    chk(uni ? "R8" : "R5", "in_ready", m, o[8], !stall);
    chk(uni ? "R8" : "R5", "fetch_stall", m, o[7], stall);
    chk("R2", "fetch_en", m, o[6], acc[m]);
    chk("R3 R6", "rd_en", m, o[5], h[m][1] > 0);
    chk("R3 R10", "alu_en", m, o[4], h[m][2] > 0);
    chk("R10", "br_en", m, o[3], h[m][2] == 4);
    chk("R9", "dmem_en", m, o[2], h[m][3] == 1 || h[m][3] == 3);
    chk("R9", "dmem_we", m, o[1], h[m][3] == 3);
    chk(uni ? "R4 R8" : "R4 R7", "rf_we", m, o[0], wr);
  endtask

  initial begin
    int seed = 32'h1d2c3b4a;
    for (int i = 0; i < PLEN; i++) begin
      if (hand(i) >= 0) prog[i] = hand(i);
      else begin
        seed = seed * 1103515245 + 12345;
        prog[i] = ((seed >>> 16) & 7) > 4 ? (((seed >>> 20) & 1) != 0 ? IDLE : 2) : ((seed >>> 16) & 7);
      end
    end
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 5; k++) h[m][k] = -1;
      idx[m] = 0; cv[m] = 0; cc[m] = 0; acc[m] = 0;
    end
    v_b = 0; c_b = 0; v_u = 0; c_u = 0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk); #1;
      chk("R1", "reset", 0, |obs_b[7:0], 1'b0);
      chk("R1", "reset_ready", 0, obs_b[8], 1'b1);
      chk("R1", "reset", 1, |obs_u[7:0], 1'b0);
      chk("R1", "reset_ready", 1, obs_u[8], 1'b1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    while (idx[0] < PLEN || idx[1] < PLEN || h[0][1] != -1 || h[0][4] != -1 ||
           h[1][1] != -1 || h[1][4] != -1 || h[0][2] != -1 || h[1][2] != -1) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
        for (int k = 4; k > 1; k--) h[m][k] = h[m][k-1];
        h[m][1] = acc[m] ? cc[m] : -1;
        if (acc[m]) idx[m]++;
        if (idx[m] < PLEN && prog[idx[m]] != IDLE) begin
          cv[m] = 1; cc[m] = prog[idx[m]];
        end else begin
          cv[m] = 0; cc[m] = 0;
          if (idx[m] < PLEN) idx[m]++;
        end
      end
      v_b = cv[0] != 0; c_b = 3'(cc[0]);
      v_u = cv[1] != 0; c_u = 3'(cc[1]);
      #1;
      check_model(0);
      check_model(1);
      acc[0] = acc[0];
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule